// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind a bus front end in a byte-wide flash memory of eight equal blocks. It turns bus writes into flash commands and decides what a bus read returns: array bytes, a status byte or identification bytes. Program, four-byte program and whole-array erase are handed to an internal program/erase engine model through a start pulse and a busy flag. The engine waits a set number of cycles and then commits the change. Two active-low protection pins can veto changes to the top block or to the other seven blocks.

Writes arrive on a valid/ready channel whose ready is always high, so one command byte can be taken every cycle. Reads arrive on a second valid/ready channel. Each accepted read yields exactly one byte on a response channel one cycle later. A read is accepted only while no response is waiting or the waiting response is being taken in the same cycle. A stalled response keeps its data unchanged. The array is a behavioural model sized by `BLK_AW` (bytes per block = 2^BLK_AW). Its contents are undefined until the first whole-array erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array, no response is pending, and the status byte reads 80h (ready, no error).
- R2: Writing FFh selects array reads, 70h selects status reads and 90h selects identification reads. Each is a single write, and the mode holds until another mode-setting command is written.
- R3: In identification mode, address 0 returns 20h, address 1 returns 26h and any other address returns 00h.
- R4: 40h followed by one write (address, data) starts a program of that byte and switches reads to status. The stored byte becomes old AND data, so no bit ever goes from 0 to 1.
- R5: 30h followed by four writes programs four bytes in one commit, using the same AND rule. The four addresses must agree in every bit above bit 1. Otherwise the error bit is set and the array is left unchanged.
- R6: 80h followed by 10h erases every byte to FFh. Any other second byte cancels the sequence and leaves the array unchanged.
- R7: While the engine is busy, status bit 7 reads 0 and every write except 70h is ignored, including FFh. Bit 7 returns to 1 when the operation completes.
- R8: With `top_lock_n` low, program in block 7 (address bits [AW-1:BLK_AW] = 7) is refused. With `main_wp_n` low, program in blocks 0 to 6 is refused. Each pin guards only its own region. Erase is refused if either pin is low.
- R9: A refused or malformed operation leaves the array unchanged and sets status bit 4. Bit 4 stays set until 50h is written while the engine is idle.
- R10: `wr_ready` is always 1 and `rd_ready` = !rsp_valid || rsp_ready. Each accepted read gives one response in the next cycle, and the response stays unchanged while `rsp_ready` is low.
- R11: In the idle state, any write byte that is not a defined opcode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (aborts any operation) |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always 1) |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write command/data byte |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 8 | Read response byte |
| top_lock_n | input | 1 | Low: block 7 protected |
| main_wp_n | input | 1 | Low: blocks 0..6 protected |

## Verification
The assertions check several rules on every cycle:
- the engine is never started while busy, and never started on a protected target;
- a single-byte program enables exactly one lane;
- each committed byte only loses bits;
- an erase commit leaves both ends of the array at FFh;
- the error bit falls only on a clear command;
- a stalled response holds its data.

Other behaviours can only be shown by the bench's scenarios against its shadow array. These are the mode selection, the identification values, the refusal of FFh during busy, quad-address mismatch, erase cancellation and the region split between the two protection pins.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS = 8'h70;
  localparam logic [7:0] OP_RD_ID     = 8'h90;
  localparam logic [7:0] OP_PROG      = 8'h40;
  localparam logic [7:0] OP_QUAD      = 8'h30;
  localparam logic [7:0] OP_ERASE_1   = 8'h80;
  localparam logic [7:0] OP_ERASE_2   = 8'h10;
  localparam logic [7:0] OP_CLR_ERR   = 8'h50;
  localparam logic [7:0] ID_BYTE0     = 8'h20;
  localparam logic [7:0] ID_BYTE1     = 8'h26;
  localparam int         BLK_SEL_W    = 3;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID} rmode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_PROG, CS_QUAD, CS_ERASE} cstate_e;
  typedef enum logic {EOP_PROG, EOP_ERASE} eop_e;
endpackage

// File: rtl/fcs_engine.sv
module fcs_engine
  import fcs_pkg::*;
#(
  parameter int AW        = 7,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  eop_e          op,
  input  logic [AW-3:0] base,
  input  logic [3:0]    lane_en,
  input  logic [31:0]   lane_data,
  output logic          busy,
  output logic          prog_we,
  output logic          erase_we,
  output logic [AW-3:0] c_base,
  output logic [3:0]    c_en,
  output logic [31:0]   c_data
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q;
  eop_e          op_q;
  logic [CW-1:0] cnt_q;
  logic          done;

  assign done     = busy_q && (cnt_q == '0);
  assign busy     = busy_q;
  assign prog_we  = done && (op_q == EOP_PROG);
  assign erase_we = done && (op_q == EOP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= EOP_PROG;
      cnt_q  <= '0;
      c_base <= '0;
      c_en   <= '0;
      c_data <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      op_q   <= op;
      cnt_q  <= (op == EOP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
      c_base <= base;
      c_en   <= lane_en;
      c_data <= lane_data;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic          erase_we,
  input  logic [AW-3:0] c_base,
  input  logic [3:0]    c_en,
  input  logic [31:0]   c_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q
);
  localparam int NB = 1 << AW;

  logic [7:0] mem [NB];

  always_ff @(posedge clk) begin
    if (erase_we) begin
      for (int k = 0; k < NB; k++) mem[k] <= 8'hFF;
    end else if (prog_we) begin
      for (int l = 0; l < 4; l++)
        if (c_en[l]) mem[{c_base, 2'(l)}] <= mem[{c_base, 2'(l)}] & c_data[8*l +: 8];
    end
  end

  assign rd_q = mem[rd_addr];

  for (genvar g = 0; g < 4; g++) begin : g_lane_chk
    logic [AW-1:0] idx;
    logic [7:0]    old;
    assign idx = {c_base, 2'(g)};
    assign old = mem[idx];
    assert_and_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we && c_en[g]) |=> ((mem[$past(idx)] & ~$past(old)) == 8'h00));
  end

  assert_erase_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (mem[0] == 8'hFF && mem[NB-1] == 8'hFF));
endmodule

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
#(
  parameter int AW     = 7,
  parameter int BLK_AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          top_lock_n,
  input  logic          main_wp_n,
  input  logic          eng_busy,
  output rmode_e        mode,
  output logic          err,
  output logic          eng_start,
  output eop_e          eng_op,
  output logic [AW-3:0] eng_base,
  output logic [3:0]    eng_lane_en,
  output logic [31:0]   eng_lane_data
);
  localparam int GW = AW - 2;

  cstate_e         cs_q, cs_d;
  rmode_e          mode_q, mode_d;
  logic            err_q, err_d;
  logic [1:0]      qcnt_q, qcnt_d;
  logic [GW-1:0]   qbase_q, qbase_d;
  logic [31:0]     qdat_q, qdat_d;
  logic [3:0]      qen_q, qen_d;
  logic            qbad_q, qbad_d;

  logic [BLK_SEL_W-1:0] wr_blk;
  logic                 wr_prot;
  logic                 q_mism;
  logic [31:0]          qdat_m;
  logic [3:0]           qen_m;

  assign wr_blk  = wr_addr[AW-1:BLK_AW];
  assign wr_prot = (wr_blk == '1) ? !top_lock_n : !main_wp_n;
  assign q_mism  = (qcnt_q != 2'd0) && (wr_addr[AW-1:2] != qbase_q);

  always_comb begin
    qdat_m = (qcnt_q == 2'd0) ? 32'hFFFF_FFFF : qdat_q;
    qen_m  = (qcnt_q == 2'd0) ? 4'h0 : qen_q;
    qdat_m[8*wr_addr[1:0] +: 8] = wr_data;
    qen_m[wr_addr[1:0]]         = 1'b1;
  end

  always_comb begin
    cs_d          = cs_q;
    mode_d        = mode_q;
    err_d         = err_q;
    qcnt_d        = qcnt_q;
    qbase_d       = qbase_q;
    qdat_d        = qdat_q;
    qen_d         = qen_q;
    qbad_d        = qbad_q;
    eng_start     = 1'b0;
    eng_op        = EOP_PROG;
    eng_base      = wr_addr[AW-1:2];
    eng_lane_en   = 4'h0;
    eng_lane_data = {4{wr_data}};
    if (wr_fire) begin
      if (eng_busy) begin
        if (wr_data == OP_RD_STATUS) mode_d = RM_STATUS;
      end else begin
        unique case (cs_q)
          CS_IDLE: begin
            unique case (wr_data)
              OP_RD_ARRAY:  mode_d = RM_ARRAY;
              OP_RD_STATUS: mode_d = RM_STATUS;
              OP_RD_ID:     mode_d = RM_ID;
              OP_CLR_ERR:   err_d  = 1'b0;
              OP_PROG:      cs_d   = CS_PROG;
              OP_QUAD: begin
                cs_d   = CS_QUAD;
                qcnt_d = 2'd0;
              end
              OP_ERASE_1:   cs_d   = CS_ERASE;
              default: ;
            endcase
          end
          CS_PROG: begin
            cs_d   = CS_IDLE;
            mode_d = RM_STATUS;
            if (wr_prot) begin
              err_d = 1'b1;
            end else begin
              eng_start                   = 1'b1;
              eng_lane_en[wr_addr[1:0]]   = 1'b1;
            end
          end
          CS_QUAD: begin
            qdat_d = qdat_m;
            qen_d  = qen_m;
            qcnt_d = qcnt_q + 2'd1;
            if (qcnt_q == 2'd0) begin
              qbase_d = wr_addr[AW-1:2];
              qbad_d  = 1'b0;
            end else begin
              qbad_d = qbad_q | q_mism;
            end
            if (qcnt_q == 2'd3) begin
              cs_d   = CS_IDLE;
              mode_d = RM_STATUS;
              if (qbad_q || q_mism || wr_prot) begin
                err_d = 1'b1;
              end else begin
                eng_start     = 1'b1;
                eng_base      = qbase_q;
                eng_lane_en   = qen_m;
                eng_lane_data = qdat_m;
              end
            end
          end
          CS_ERASE: begin
            cs_d = CS_IDLE;
            if (wr_data == OP_ERASE_2) begin
              mode_d = RM_STATUS;
              if (!top_lock_n || !main_wp_n) begin
                err_d = 1'b1;
              end else begin
                eng_start = 1'b1;
                eng_op    = EOP_ERASE;
              end
            end
          end
          default: cs_d = CS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= CS_IDLE;
      mode_q  <= RM_ARRAY;
      err_q   <= 1'b0;
      qcnt_q  <= 2'd0;
      qbase_q <= '0;
      qdat_q  <= '1;
      qen_q   <= 4'h0;
      qbad_q  <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
      qcnt_q  <= qcnt_d;
      qbase_q <= qbase_d;
      qdat_q  <= qdat_d;
      qen_q   <= qen_d;
      qbad_q  <= qbad_d;
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
  assert_busy_no_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (mode_q != RM_ARRAY));
  assert_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && cs_q == CS_PROG) |-> ($countones(eng_lane_en) == 1));
  assert_prog_unprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_op == EOP_PROG) |->
      ((eng_base[GW-1:BLK_AW-2] == '1) ? top_lock_n : main_wp_n));
  assert_erase_unprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_op == EOP_ERASE) |-> (top_lock_n && main_wp_n));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(wr_fire && wr_data == OP_CLR_ERR));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int BLK_AW    = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 24,
  localparam int AW       = BLK_AW + BLK_SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_data,
  input  logic          top_lock_n,
  input  logic          main_wp_n
);
  rmode_e        mode;
  logic          err;
  logic          eng_start, eng_busy;
  eop_e          eng_op;
  logic [AW-3:0] eng_base, c_base;
  logic [3:0]    eng_lane_en, c_en;
  logic [31:0]   eng_lane_data, c_data;
  logic          prog_we, erase_we;
  logic [7:0]    arr_q, stat_b, id_b, rd_sel;
  logic          wr_fire, rd_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_fire  = rd_valid && rd_ready;

  fcs_decode #(.AW(AW), .BLK_AW(BLK_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .top_lock_n(top_lock_n), .main_wp_n(main_wp_n),
    .eng_busy(eng_busy), .mode(mode), .err(err), .eng_start(eng_start),
    .eng_op(eng_op), .eng_base(eng_base), .eng_lane_en(eng_lane_en),
    .eng_lane_data(eng_lane_data)
  );

  fcs_engine #(.AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .op(eng_op),
    .base(eng_base), .lane_en(eng_lane_en), .lane_data(eng_lane_data),
    .busy(eng_busy), .prog_we(prog_we), .erase_we(erase_we),
    .c_base(c_base), .c_en(c_en), .c_data(c_data)
  );

  fcs_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .erase_we(erase_we),
    .c_base(c_base), .c_en(c_en), .c_data(c_data),
    .rd_addr(rd_addr), .rd_q(arr_q)
  );

  assign stat_b = {!eng_busy, 2'b00, err, 4'h0};
  assign id_b   = (rd_addr == AW'(0)) ? ID_BYTE0 :
                  (rd_addr == AW'(1)) ? ID_BYTE1 : 8'h00;

  always_comb begin
    unique case (mode)
      RM_STATUS: rd_sel = stat_b;
      RM_ID:     rd_sel = id_b;
      default:   rd_sel = arr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int BLK_AW = 4;
  localparam int AW     = BLK_AW + 3;
  localparam int NB     = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic          rd_valid = 1'b0, rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rsp_valid, rsp_ready = 1'b0;
  logic [7:0]    rsp_data;
  logic          top_lock_n = 1'b1, main_wp_n = 1'b1;

  int total = 0;
  int bad   = 0;
  logic [7:0] shadow [NB];

  flash_cmd_seq #(.BLK_AW(BLK_AW), .PROG_CYC(6), .ERASE_CYC(24)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .top_lock_n(top_lock_n),
    .main_wp_n(main_wp_n)
  );

  function automatic logic prot_f(logic [AW-1:0] a, logic tl, logic wp);
    return (a[AW-1:BLK_AW] == 3'd7) ? !tl : !wp;
  endfunction

  function automatic logic [7:0] id_f(logic [AW-1:0] a);
    return (a == 0) ? 8'h20 : (a == 1) ? 8'h26 : 8'h00;
  endfunction

  function automatic logic [7:0] stat_f(logic rdy, logic e);
    return {rdy, 2'b00, e, 4'h0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    d = rsp_data;
    if (!rsp_valid) d = 8'hXX;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_ready(output logic [7:0] s);
    wr('0, 8'h70);
    for (int i = 0; i < 100; i++) begin
      rd('0, s);
      if (s[7] === 1'b1) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_byte(string tag, logic [AW-1:0] a);
    logic [7:0] v;
    wr('0, 8'hFF);
    rd(a, v);
    chk(tag, v, shadow[a]);
  endtask

  task automatic prog1(logic [AW-1:0] a, logic [7:0] d, string tag);
    logic [7:0] s;
    logic e;
    e = prot_f(a, top_lock_n, main_wp_n);
    wr('0, 8'h40);
    wr(a, d);
    if (!e) shadow[a] = shadow[a] & d;
    wait_ready(s);
    chk({tag, " status"}, s, stat_f(1'b1, e));
    if (e) wr('0, 8'h50);
    check_byte({tag, " data"}, a);
  endtask

  task automatic quad4(logic [AW-1:0] a0, logic [AW-1:0] a1, logic [AW-1:0] a2,
                       logic [AW-1:0] a3, logic [31:0] d, string tag);
    logic [7:0] s;
    logic e;
    e = (a1[AW-1:2] != a0[AW-1:2]) || (a2[AW-1:2] != a0[AW-1:2]) ||
        (a3[AW-1:2] != a0[AW-1:2]) || prot_f(a0, top_lock_n, main_wp_n);
    wr('0, 8'h30);
    wr(a0, d[7:0]); wr(a1, d[15:8]); wr(a2, d[23:16]); wr(a3, d[31:24]);
    if (!e) begin
      shadow[a0] = shadow[a0] & d[7:0];
      shadow[a1] = shadow[a1] & d[15:8];
      shadow[a2] = shadow[a2] & d[23:16];
      shadow[a3] = shadow[a3] & d[31:24];
    end
    wait_ready(s);
    chk({tag, " status"}, s, stat_f(1'b1, e));
    if (e) wr('0, 8'h50);
    check_byte({tag, " b0"}, a0);
    check_byte({tag, " b1"}, a1);
    check_byte({tag, " b2"}, a2);
    check_byte({tag, " b3"}, a3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NB; k++) shadow[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    chk("R1 rsp_valid after reset", {7'd0, rsp_valid}, 8'h00);
    chk("R10 rd_ready after reset", {7'd0, rd_ready}, 8'h01);
    chk("R10 wr_ready", {7'd0, wr_ready}, 8'h01);
    wr('0, 8'h70);
    rd('0, v);
    chk("R1 status after reset", v, 8'h80);

    // R6 erase, R7 busy visible
    wr('0, 8'h80); wr('0, 8'h10);
    rd('0, v);
    chk("R7 busy bit during erase", v, 8'h00);
    wait_ready(v);
    chk("R6 erase status", v, 8'h80);
    check_byte("R6 erased low", 7'd0);
    check_byte("R6 erased high", 7'(NB - 1));

    // R1 reset returns to array reads
    wr('0, 8'h70);
    do_reset();
    rd(7'd5, v);
    chk("R1 array mode after reset", v, 8'hFF);

    // R2/R3 identification mode
    wr('0, 8'h90);
    rd(7'd0, v); chk("R3 id offset 0", v, 8'h20);
    rd(7'd1, v); chk("R3 id offset 1", v, 8'h26);
    rd(7'd2, v); chk("R3 id offset 2", v, id_f(7'd2));
    rd(7'd1, v); chk("R2 id mode persists", v, 8'h26);
    // R11 undefined opcode ignored
    wr('0, 8'h12);
    rd(7'd0, v); chk("R11 unknown opcode ignored", v, 8'h20);

    // R4 / R7 program with FFh during busy
    wr('0, 8'h40); wr(7'h13, 8'hA5);
    wr('0, 8'hFF);
    rd(7'h13, v);
    chk("R7 FFh ignored while busy", v & 8'h7F, 8'h00);
    shadow[7'h13] = 8'hA5;
    wait_ready(v);
    chk("R4 program status", v, 8'h80);
    check_byte("R4 program data", 7'h13);
    prog1(7'h13, 8'hFF, "R4 no 0to1");
    prog1(7'h13, 8'h5A, "R4 and rule");

    // R8 / R9 protection regions
    top_lock_n = 1'b0;
    wr('0, 8'h40); wr(7'h73, 8'h00);
    wr('0, 8'h70);
    rd('0, v); chk("R9 error sticky", v, 8'h90);
    wr('0, 8'h70);
    rd('0, v); chk("R9 error still set", v, 8'h90);
    wr('0, 8'h50);
    rd('0, v); chk("R9 cleared", v, 8'h80);
    check_byte("R8 top block unchanged", 7'h73);
    prog1(7'h21, 8'h0F, "R8 main ok with top lock");
    top_lock_n = 1'b1; main_wp_n = 1'b0;
    prog1(7'h02, 8'h00, "R8 main protected");
    prog1(7'h75, 8'h3C, "R8 top ok with wp");
    wr('0, 8'h80); wr('0, 8'h10);
    wait_ready(v);
    chk("R8 erase refused status", v, 8'h90);
    wr('0, 8'h50);
    check_byte("R8 erase refused data", 7'h75);
    main_wp_n = 1'b1;

    // R5 quad program
    quad4(7'h46, 7'h44, 7'h47, 7'h45, 32'h1234_5678, "R5 quad ok");
    quad4(7'h50, 7'h51, 7'h56, 7'h53, 32'h0000_0000, "R5 quad mismatch");

    // R6 erase cancel
    wr('0, 8'h80); wr('0, 8'h55);
    wr('0, 8'h70);
    rd('0, v); chk("R6 cancel no busy", v, 8'h80);
    check_byte("R6 cancel array kept", 7'h13);

    // R10 back-pressure
    wr('0, 8'h90);
    @(negedge clk); rd_valid = 1'b1; rd_addr = 7'd1;
    @(negedge clk); rd_valid = 1'b0; rd_addr = 7'd0;
    v0 = rsp_data;
    repeat (3) @(negedge clk);
    chk("R10 rd_ready low while stalled", {7'd0, rd_ready}, 8'h00);
    chk("R10 response held", rsp_data, v0);
    chk("R10 response value", rsp_data, 8'h26);
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
    chk("R10 response drained", {7'd0, rsp_valid}, 8'h00);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a;
      int r;
      a = AW'($urandom_range(0, NB - 1));
      top_lock_n = ($urandom_range(0, 3) != 0);
      main_wp_n  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 0) begin
        prog1(a, 8'($urandom), "R4 random program");
      end else begin
        r = $urandom_range(0, 3);
        quad4({a[AW-1:2], 2'(r)}, {a[AW-1:2], 2'(r + 1)},
              {a[AW-1:2], 2'(r + 2)}, {a[AW-1:2], 2'(r + 3)},
              $urandom, "R5 random quad");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule